// File: doc/BRIEF.md
# Exception Entry Vector Controller

This block performs the register side of processor exception entry in a single clock. The core presents a strobe with an exception kind, the program counter of the faulting instruction, a delay-slot flag, a TLB-refill flag, the coprocessor number for coprocessor-unusable faults, and the current Status, Cause and exception-base register values. On the following edge the block registers the new program counter, the captured return addresses (EPC, ErrorEPC and debug EPC), and the updated Status and Cause words, and raises a one-cycle redirect pulse so the core can fetch from the vector and write the updated Status and Cause back into its register file.

Three classes of entry are handled. General exceptions write a 5-bit cause code, capture EPC only when the exception level is clear, and pick a vector offset from the exception kind, the nesting state, the interrupt-vector bit and the boot-vector bit. Error-level entries (non-maskable interrupt and soft reset) capture ErrorEPC and jump to the reset vector. Debug entry captures the debug EPC, sets debug mode and jumps to the debug vector. Every capture backs up one instruction (4 bytes) when the faulting instruction sits in a branch delay slot.

Top module: `exc_entry_ctrl`

## Requirements
- R1: The kind input for a general exception equals its cause code (interrupt 0, TLB modify 1, TLB load 2, TLB store 3, address error load 4, address error store 5, instruction bus error 6, data bus error 7, syscall 8, breakpoint 9, reserved instruction 10, coprocessor unusable 11, overflow 12, trap 13, floating point 15, machine check 24, cache error 30), which is written into Cause bits 6:2; kind 16 is NMI, 17 soft reset, 31 debug; every other kind value is ignored, leaving all outputs unchanged and no redirect.
- R2: A general exception with no special offset jumps to base + 0x180.
- R3: The vector base is 0xBFC00200 when Status bit 22 (boot vector) is set, otherwise the exception base input with bits 9:0 cleared.
- R4: An interrupt (kind 0) uses offset 0x200 when Cause bit 23 is set, else 0x180.
- R5: A TLB load or store with the refill flag set and Status bit 1 (exception level) clear uses offset 0x000; with the level set, or for any other kind, the refill flag has no effect.
- R6: A cache error uses offset 0x100 when the boot-vector bit is set and 0x20000100 otherwise.
- R7: A general exception with the exception level clear writes EPC as PC − 4 (modulo 2^32) with Cause bit 31 set when in a delay slot, else PC with bit 31 cleared; Status bit 1 is set on every general entry.
- R8: A general exception with the exception level already set leaves EPC and Cause bit 31 unchanged while still writing the cause code.
- R9: Coprocessor unusable writes the 2-bit coprocessor number into Cause bits 29:28; other kinds pass those bits through from the Cause input.
- R10: NMI and soft reset write ErrorEPC with the delay-slot rule, set Status bits 2 and 22, clear Status bits 4:3, set Status bit 19 (NMI) or bit 20 (soft reset), clear Cause bit 31 when the level is clear, leave EPC alone and jump to 0xBFC00000.
- R11: Debug entry writes the debug EPC with the delay-slot rule, sets the debug-mode output, passes Status through, clears Cause bit 31 when the level is clear and jumps to 0xBFC00480.
- R12: After reset all outputs are zero; without an accepted strobe all outputs hold, and the redirect output is high for exactly the cycle after an accepted strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid | input | 1 | Exception entry strobe |
| exc_kind | input | 5 | Exception kind (cause code or special kind) |
| pc_i | input | 32 | PC of the faulting instruction |
| in_delay_slot | input | 1 | Faulting instruction is in a branch delay slot |
| tlb_refill | input | 1 | TLB fault was a missing entry (refill) |
| cop_num | input | 2 | Coprocessor number for coprocessor-unusable |
| status_i | input | 32 | Current Status register |
| cause_i | input | 32 | Current Cause register |
| exc_base_i | input | 32 | Exception base register |
| redirect_o | output | 1 | One-cycle pulse: new PC is valid |
| new_pc_o | output | 32 | Vector target |
| epc_o | output | 32 | Captured exception PC |
| err_epc_o | output | 32 | Captured error PC |
| dbg_epc_o | output | 32 | Captured debug PC |
| cause_o | output | 32 | Updated Cause value |
| status_o | output | 32 | Updated Status value |
| debug_mode_o | output | 1 | Debug mode entered |

## Verification
The bench targets the offset selection corners: a TLB refill taken while already nested (a design ignoring the level bit would land on offset 0 instead of 0x180), a refill flag on TLB modify, an interrupt with and without the vector bit, and a cache error under both boot-vector settings, where a wrong mux would jump into the general vector. It drives a delay-slot fault at PC 0 so a broken subtraction shows up as a wrong wrap value, and nested faults to catch EPC or BD being overwritten. Reserved kind codes and idle cycles with changing inputs check that nothing moves, which catches a design that decodes unknown kinds as general faults or loads without a strobe.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  // Kind codes; general kinds equal their cause code
  localparam logic [4:0] KIND_INT    = 5'd0;
  localparam logic [4:0] KIND_TMOD   = 5'd1;
  localparam logic [4:0] KIND_TLD    = 5'd2;
  localparam logic [4:0] KIND_TST    = 5'd3;
  localparam logic [4:0] KIND_ALD    = 5'd4;
  localparam logic [4:0] KIND_AST    = 5'd5;
  localparam logic [4:0] KIND_IBUS   = 5'd6;
  localparam logic [4:0] KIND_DBUS   = 5'd7;
  localparam logic [4:0] KIND_SYS    = 5'd8;
  localparam logic [4:0] KIND_BRK    = 5'd9;
  localparam logic [4:0] KIND_RSVD   = 5'd10;
  localparam logic [4:0] KIND_COP    = 5'd11;
  localparam logic [4:0] KIND_OVF    = 5'd12;
  localparam logic [4:0] KIND_TRAP   = 5'd13;
  localparam logic [4:0] KIND_FPU    = 5'd15;
  localparam logic [4:0] KIND_NMI    = 5'd16;
  localparam logic [4:0] KIND_SRST   = 5'd17;
  localparam logic [4:0] KIND_MCHK   = 5'd24;
  localparam logic [4:0] KIND_CACHE  = 5'd30;
  localparam logic [4:0] KIND_DEBUG  = 5'd31;

  // Register field positions
  localparam int ST_EXL  = 1;
  localparam int ST_ERL  = 2;
  localparam int ST_KSU_LO = 3;
  localparam int ST_KSU_HI = 4;
  localparam int ST_NMI  = 19;
  localparam int ST_SR   = 20;
  localparam int ST_BEV  = 22;
  localparam int CA_CODE_LO = 2;
  localparam int CA_CODE_HI = 6;
  localparam int CA_IV   = 23;
  localparam int CA_CE_LO = 28;
  localparam int CA_CE_HI = 29;
  localparam int CA_BD   = 31;

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_GEN  = 2'd1,
    CLS_ERR  = 2'd2,
    CLS_DBG  = 2'd3
  } exc_class_e;

  typedef struct packed {
    exc_class_e cls;
    logic [4:0] code;
    logic       is_int;
    logic       is_tlb_ls;
    logic       is_cache;
    logic       is_cop;
    logic       is_srst;
  } exc_decode_t;

endpackage

// File: rtl/exc_cause_enc.sv
module exc_cause_enc
  import exc_entry_pkg::*;
(
  input  logic [4:0]  kind_i,
  output exc_decode_t dec_o
);

  always_comb begin
    dec_o           = '0;
    dec_o.cls       = CLS_NONE;
    dec_o.code      = kind_i;
    dec_o.is_int    = (kind_i == KIND_INT);
    dec_o.is_tlb_ls = (kind_i == KIND_TLD) || (kind_i == KIND_TST);
    dec_o.is_cache  = (kind_i == KIND_CACHE);
    dec_o.is_cop    = (kind_i == KIND_COP);
    dec_o.is_srst   = (kind_i == KIND_SRST);
    unique case (kind_i)
      KIND_INT, KIND_TMOD, KIND_TLD, KIND_TST, KIND_ALD, KIND_AST,
      KIND_IBUS, KIND_DBUS, KIND_SYS, KIND_BRK, KIND_RSVD, KIND_COP,
      KIND_OVF, KIND_TRAP, KIND_FPU, KIND_MCHK, KIND_CACHE:
        dec_o.cls = CLS_GEN;
      KIND_NMI, KIND_SRST:
        dec_o.cls = CLS_ERR;
      KIND_DEBUG:
        dec_o.cls = CLS_DBG;
      default:
        dec_o.cls = CLS_NONE;
    endcase
  end

endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
  import exc_entry_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter int          BASE_ALIGN = 10,
  parameter logic [31:0] BOOT_BASE  = 32'hBFC0_0200,
  parameter logic [31:0] RESET_VEC  = 32'hBFC0_0000,
  parameter logic [31:0] DEBUG_VEC  = 32'hBFC0_0480,
  parameter logic [31:0] OFF_GEN    = 32'h0000_0180,
  parameter logic [31:0] OFF_IV     = 32'h0000_0200,
  parameter logic [31:0] OFF_REFILL = 32'h0000_0000,
  parameter logic [31:0] OFF_CE_BOOT = 32'h0000_0100,
  parameter logic [31:0] OFF_CE_RUN  = 32'h2000_0100
) (
  input  exc_decode_t     dec_i,
  input  logic            bev_i,
  input  logic            exl_i,
  input  logic            iv_i,
  input  logic            refill_i,
  input  logic [XLEN-1:0] ebase_i,
  output logic [XLEN-1:0] target_o
);

  localparam logic [XLEN-1:0] BASE_MASK = ~((XLEN'(1) << BASE_ALIGN) - XLEN'(1));

  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offset;

  // Vector base: boot ROM region or software-relocated base
  always_comb begin
    base = bev_i ? XLEN'(BOOT_BASE) : (ebase_i & BASE_MASK);
  end

  // Offset priority: cache error, vectored interrupt, refill, default
  always_comb begin
    if (dec_i.is_cache)
      offset = bev_i ? XLEN'(OFF_CE_BOOT) : XLEN'(OFF_CE_RUN);
    else if (dec_i.is_int && iv_i)
      offset = XLEN'(OFF_IV);
    else if (dec_i.is_tlb_ls && refill_i && !exl_i)
      offset = XLEN'(OFF_REFILL);
    else
      offset = XLEN'(OFF_GEN);
  end

  always_comb begin
    unique case (dec_i.cls)
      CLS_ERR: target_o = XLEN'(RESET_VEC);
      CLS_DBG: target_o = XLEN'(DEBUG_VEC);
      default: target_o = base + offset;
    endcase
  end

  always_comb begin
    if (dec_i.is_cache && dec_i.cls != CLS_GEN)
      assert (1'b0) else $error("a_r6_cache_class: cache kind decoded outside general class");
  end

endmodule

// File: rtl/exc_capture.sv
module exc_capture
  import exc_entry_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter int          INSN_BYTES = 4,
  parameter logic [31:0] RESET_VEC = 32'hBFC0_0000,
  parameter logic [31:0] DEBUG_VEC = 32'hBFC0_0480
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            strobe_i,
  input  exc_decode_t     dec_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic            ds_i,
  input  logic [1:0]      cop_i,
  input  logic [31:0]     status_i,
  input  logic [31:0]     cause_i,
  input  logic [XLEN-1:0] target_i,
  output logic            redirect_o,
  output logic [XLEN-1:0] new_pc_o,
  output logic [XLEN-1:0] epc_o,
  output logic [XLEN-1:0] err_epc_o,
  output logic [XLEN-1:0] dbg_epc_o,
  output logic [31:0]     cause_o,
  output logic [31:0]     status_o,
  output logic            debug_mode_o
);

  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  logic            take;
  logic            exl;
  logic [XLEN-1:0] ret_pc;
  logic [31:0]     cause_nx;
  logic [31:0]     status_nx;

  assign take = strobe_i && (dec_i.cls != CLS_NONE);
  assign exl  = status_i[ST_EXL];

  // Return address backs up over the branch for delay-slot faults
  always_comb begin
    ret_pc = ds_i ? (pc_i - STEP) : pc_i;
  end

  always_comb begin
    cause_nx  = cause_i;
    status_nx = status_i;
    unique case (dec_i.cls)
      CLS_GEN: begin
        cause_nx[CA_CODE_HI:CA_CODE_LO] = dec_i.code;
        if (dec_i.is_cop)
          cause_nx[CA_CE_HI:CA_CE_LO] = cop_i;
        if (!exl)
          cause_nx[CA_BD] = ds_i;
        status_nx[ST_EXL] = 1'b1;
      end
      CLS_ERR: begin
        if (!exl)
          cause_nx[CA_BD] = 1'b0;
        status_nx[ST_ERL] = 1'b1;
        status_nx[ST_BEV] = 1'b1;
        status_nx[ST_KSU_HI:ST_KSU_LO] = 2'b00;
        if (dec_i.is_srst)
          status_nx[ST_SR] = 1'b1;
        else
          status_nx[ST_NMI] = 1'b1;
      end
      CLS_DBG: begin
        if (!exl)
          cause_nx[CA_BD] = 1'b0;
      end
      default: begin
        cause_nx  = cause_i;
        status_nx = status_i;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirect_o   <= 1'b0;
      new_pc_o     <= '0;
      epc_o        <= '0;
      err_epc_o    <= '0;
      dbg_epc_o    <= '0;
      cause_o      <= '0;
      status_o     <= '0;
      debug_mode_o <= 1'b0;
    end else begin
      redirect_o <= take;
      if (take) begin
        new_pc_o <= target_i;
        cause_o  <= cause_nx;
        status_o <= status_nx;
        unique case (dec_i.cls)
          CLS_GEN: if (!exl) epc_o <= ret_pc;
          CLS_ERR: err_epc_o <= ret_pc;
          CLS_DBG: begin
            dbg_epc_o    <= ret_pc;
            debug_mode_o <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_i |=> ($stable(new_pc_o) && $stable(epc_o) && $stable(err_epc_o) &&
                   $stable(dbg_epc_o) && $stable(cause_o) && $stable(status_o) &&
                   !redirect_o))
    else $error("a_r12_hold");

  a_r12_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> $past(strobe_i))
    else $error("a_r12_pulse");

  a_r7_level_set: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && dec_i.cls == CLS_GEN) |=> status_o[ST_EXL])
    else $error("a_r7_level_set");

  a_r7_delay_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && dec_i.cls == CLS_GEN && !status_i[ST_EXL] && ds_i)
      |=> (epc_o == $past(pc_i) - STEP) && cause_o[CA_BD])
    else $error("a_r7_delay_slot");

  a_r8_epc_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && dec_i.cls == CLS_GEN && status_i[ST_EXL]) |=> $stable(epc_o))
    else $error("a_r8_epc_keep");

  a_r10_error_level: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && dec_i.cls == CLS_ERR)
      |=> (status_o[ST_ERL] && status_o[ST_BEV] && new_pc_o == XLEN'(RESET_VEC) && $stable(epc_o)))
    else $error("a_r10_error_level");

  a_r11_debug: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && dec_i.cls == CLS_DBG) |=> (debug_mode_o && new_pc_o == XLEN'(DEBUG_VEC)))
    else $error("a_r11_debug");

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter int          BASE_ALIGN = 10,
  parameter logic [31:0] BOOT_BASE  = 32'hBFC0_0200,
  parameter logic [31:0] RESET_VEC  = 32'hBFC0_0000,
  parameter logic [31:0] DEBUG_VEC  = 32'hBFC0_0480
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exc_valid,
  input  logic [4:0]      exc_kind,
  input  logic [XLEN-1:0] pc_i,
  input  logic            in_delay_slot,
  input  logic            tlb_refill,
  input  logic [1:0]      cop_num,
  input  logic [31:0]     status_i,
  input  logic [31:0]     cause_i,
  input  logic [XLEN-1:0] exc_base_i,
  output logic            redirect_o,
  output logic [XLEN-1:0] new_pc_o,
  output logic [XLEN-1:0] epc_o,
  output logic [XLEN-1:0] err_epc_o,
  output logic [XLEN-1:0] dbg_epc_o,
  output logic [31:0]     cause_o,
  output logic [31:0]     status_o,
  output logic            debug_mode_o
);

  exc_decode_t     dec;
  logic [XLEN-1:0] target;

  exc_cause_enc u_enc (
    .kind_i (exc_kind),
    .dec_o  (dec)
  );

  exc_vector_sel #(
    .XLEN       (XLEN),
    .BASE_ALIGN (BASE_ALIGN),
    .BOOT_BASE  (BOOT_BASE),
    .RESET_VEC  (RESET_VEC),
    .DEBUG_VEC  (DEBUG_VEC)
  ) u_vec (
    .dec_i    (dec),
    .bev_i    (status_i[ST_BEV]),
    .exl_i    (status_i[ST_EXL]),
    .iv_i     (cause_i[CA_IV]),
    .refill_i (tlb_refill),
    .ebase_i  (exc_base_i),
    .target_o (target)
  );

  exc_capture #(
    .XLEN      (XLEN),
    .RESET_VEC (RESET_VEC),
    .DEBUG_VEC (DEBUG_VEC)
  ) u_cap (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe_i     (exc_valid),
    .dec_i        (dec),
    .pc_i         (pc_i),
    .ds_i         (in_delay_slot),
    .cop_i        (cop_num),
    .status_i     (status_i),
    .cause_i      (cause_i),
    .target_i     (target),
    .redirect_o   (redirect_o),
    .new_pc_o     (new_pc_o),
    .epc_o        (epc_o),
    .err_epc_o    (err_epc_o),
    .dbg_epc_o    (dbg_epc_o),
    .cause_o      (cause_o),
    .status_o     (status_o),
    .debug_mode_o (debug_mode_o)
  );

  a_r1_ignore_unknown: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && dec.cls == CLS_NONE) |=> (!redirect_o && $stable(cause_o) && $stable(new_pc_o)))
    else $error("a_r1_ignore_unknown");

  a_r1_code_written: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && dec.cls == CLS_GEN) |=> (cause_o[CA_CODE_HI:CA_CODE_LO] == $past(exc_kind)))
    else $error("a_r1_code_written");

endmodule

// File: tb/exc_entry_ctrl_tb.sv
module exc_entry_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_valid = 1'b0;
  logic [4:0]  exc_kind = '0;
  logic [31:0] pc_i = '0;
  logic        in_delay_slot = 1'b0;
  logic        tlb_refill = 1'b0;
  logic [1:0]  cop_num = '0;
  logic [31:0] status_i = '0;
  logic [31:0] cause_i = '0;
  logic [31:0] exc_base_i = '0;
  logic        redirect_o;
  logic [31:0] new_pc_o, epc_o, err_epc_o, dbg_epc_o, cause_o, status_o;
  logic        debug_mode_o;

  int n_checks = 0;
  int n_fail = 0;

  // Bench model of the outputs
  logic [31:0] m_pc, m_epc, m_err, m_depc, m_cause, m_status;
  logic        m_dbg, m_redir;

  always #4 clk = ~clk;

  exc_entry_ctrl u_dut (
    .clk (clk), .rst_n (rst_n), .exc_valid (exc_valid), .exc_kind (exc_kind),
    .pc_i (pc_i), .in_delay_slot (in_delay_slot), .tlb_refill (tlb_refill),
    .cop_num (cop_num), .status_i (status_i), .cause_i (cause_i),
    .exc_base_i (exc_base_i), .redirect_o (redirect_o), .new_pc_o (new_pc_o),
    .epc_o (epc_o), .err_epc_o (err_epc_o), .dbg_epc_o (dbg_epc_o),
    .cause_o (cause_o), .status_o (status_o), .debug_mode_o (debug_mode_o)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int kind_class(input logic [4:0] k);
    // 1 general, 2 error level, 3 debug, 0 ignored
    if (k <= 5'd13 || k == 5'd15 || k == 5'd24 || k == 5'd30) return 1;
    if (k == 5'd16 || k == 5'd17) return 2;
    if (k == 5'd31) return 3;
    return 0;
  endfunction

  function automatic logic [31:0] exp_target(input logic [4:0] k, input logic [31:0] st,
                                             input logic [31:0] ca, input logic [31:0] eb,
                                             input logic rf);
    logic [31:0] base, off;
    if (k == 5'd16 || k == 5'd17) return 32'hBFC00000;
    if (k == 5'd31) return 32'hBFC00480;
    base = st[22] ? 32'hBFC00200 : {eb[31:10], 10'b0};
    if (k == 5'd30) off = st[22] ? 32'h100 : 32'h20000100;
    else if (k == 5'd0 && ca[23]) off = 32'h200;
    else if ((k == 5'd2 || k == 5'd3) && rf && !st[1]) off = 32'h0;
    else off = 32'h180;
    return base + off;
  endfunction

  function automatic string pc_tag(input logic [4:0] k, input logic [31:0] st,
                                   input logic [31:0] ca, input logic rf);
    if (k == 5'd16 || k == 5'd17) return "R10";
    if (k == 5'd31) return "R11";
    if (k == 5'd30) return "R6";
    if (k == 5'd0) return ca[23] ? "R4" : (st[22] ? "R2" : "R3");
    if ((k == 5'd2 || k == 5'd3) && rf) return "R5";
    return st[22] ? "R2" : "R3";
  endfunction

  task automatic compare_all(input string ptag, input string etag, input string ctag, input string stag);
    chk("R12", "redirect", {31'b0, redirect_o}, {31'b0, m_redir});
    chk(ptag, "new_pc", new_pc_o, m_pc);
    chk(etag, "epc", epc_o, m_epc);
    chk("R10", "err_epc", err_epc_o, m_err);
    chk("R11", "dbg_epc", dbg_epc_o, m_depc);
    chk(ctag, "cause", cause_o, m_cause);
    chk(stag, "status", status_o, m_status);
    chk("R11", "debug_mode", {31'b0, debug_mode_o}, {31'b0, m_dbg});
  endtask

  task automatic do_exc(input logic [4:0] k, input logic [31:0] pc, input logic ds,
                        input logic rf, input logic [1:0] cp, input logic [31:0] st,
                        input logic [31:0] ca, input logic [31:0] eb);
    int cls;
    logic [31:0] ret, c, s;
    string ptag, etag, ctag, stag;
    @(negedge clk);
    exc_valid = 1'b1; exc_kind = k; pc_i = pc; in_delay_slot = ds; tlb_refill = rf;
    cop_num = cp; status_i = st; cause_i = ca; exc_base_i = eb;
    cls = kind_class(k);
    ret = ds ? pc - 32'd4 : pc;
    ptag = "R1"; etag = "R1"; ctag = "R1"; stag = "R1";
    m_redir = (cls != 0);
    if (cls != 0) begin
      m_pc = exp_target(k, st, ca, eb, rf);
      ptag = pc_tag(k, st, ca, rf);
      c = ca; s = st;
      if (cls == 1) begin
        c[6:2] = k;
        if (k == 5'd11) c[29:28] = cp;
        if (!st[1]) begin c[31] = ds; m_epc = ret; etag = "R7"; end
        else etag = "R8";
        s[1] = 1'b1;
        ctag = (k == 5'd11) ? "R9" : (st[1] ? "R8" : "R7");
        stag = "R7";
      end else begin
        if (!st[1]) c[31] = 1'b0;
        if (cls == 2) begin
          s[2] = 1'b1; s[22] = 1'b1; s[4:3] = 2'b00;
          if (k == 5'd17) s[20] = 1'b1; else s[19] = 1'b1;
          m_err = ret; etag = "R10"; ctag = "R10"; stag = "R10";
        end else begin
          m_depc = ret; m_dbg = 1'b1; etag = "R11"; ctag = "R11"; stag = "R11";
        end
      end
      m_cause = c; m_status = s;
    end
    @(posedge clk); #1;
    compare_all(ptag, etag, ctag, stag);
    // Idle cycle with scrambled inputs: everything holds
    @(negedge clk);
    exc_valid = 1'b0; exc_kind = 5'($urandom); pc_i = $urandom; status_i = $urandom;
    cause_i = $urandom; exc_base_i = $urandom; in_delay_slot = 1'($urandom);
    m_redir = 1'b0;
    @(posedge clk); #1;
    compare_all("R12", "R12", "R12", "R12");
  endtask

  initial begin
    #(8 * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed_sink;
    seed_sink = $urandom(32'd24680);
    m_pc = 0; m_epc = 0; m_err = 0; m_depc = 0; m_cause = 0; m_status = 0;
    m_dbg = 0; m_redir = 0;
    repeat (3) @(posedge clk);
    #1;
    compare_all("R12", "R12", "R12", "R12");
    @(negedge clk); rst_n = 1'b1;

    // Directed corners
    do_exc(5'd8,  32'h0000_1000, 1'b0, 1'b0, 2'd0, 32'h0040_0000, 32'h0, 32'h0);          // R2 boot base
    do_exc(5'd12, 32'h0000_2000, 1'b0, 1'b0, 2'd0, 32'h0000_0000, 32'h0, 32'h8123_45FF);  // R3 mask
    do_exc(5'd0,  32'h0000_3000, 1'b0, 1'b0, 2'd0, 32'h0000_0000, 32'h0080_0000, 32'h8000_0000); // R4 IV
    do_exc(5'd0,  32'h0000_3004, 1'b0, 1'b0, 2'd0, 32'h0040_0000, 32'h0, 32'h0);          // R4 no IV
    do_exc(5'd2,  32'h0000_4000, 1'b0, 1'b1, 2'd0, 32'h0000_0000, 32'h0, 32'h8000_0000);  // R5 refill
    do_exc(5'd3,  32'h0000_4004, 1'b1, 1'b1, 2'd0, 32'h0040_0000, 32'h0, 32'h0);          // R5 store refill
    do_exc(5'd2,  32'h0000_4008, 1'b0, 1'b1, 2'd0, 32'h0000_0002, 32'h0, 32'h8000_0000);  // R5 nested
    do_exc(5'd1,  32'h0000_400C, 1'b0, 1'b1, 2'd0, 32'h0000_0000, 32'h0, 32'h8000_0000);  // R5 modify
    do_exc(5'd30, 32'h0000_5000, 1'b0, 1'b0, 2'd0, 32'h0040_0000, 32'h0, 32'h0);          // R6 boot
    do_exc(5'd30, 32'h0000_5004, 1'b0, 1'b0, 2'd0, 32'h0000_0000, 32'h0, 32'h8000_0400);  // R6 run
    do_exc(5'd11, 32'h0000_6000, 1'b0, 1'b0, 2'd3, 32'h0000_0000, 32'h0, 32'h0);          // R9
    do_exc(5'd9,  32'h0000_0000, 1'b1, 1'b0, 2'd0, 32'h0000_0000, 32'h0, 32'h0);          // R7 wrap
    do_exc(5'd4,  32'h0000_7000, 1'b1, 1'b0, 2'd0, 32'h0000_0002, 32'h0, 32'h0);          // R8 nested
    do_exc(5'd16, 32'h0000_8000, 1'b1, 1'b0, 2'd0, 32'h0000_0018, 32'h8000_0000, 32'h0);  // R10 NMI
    do_exc(5'd17, 32'h0000_9000, 1'b0, 1'b0, 2'd0, 32'h0000_0012, 32'h8000_0000, 32'h0);  // R10 soft reset
    do_exc(5'd31, 32'h0000_A000, 1'b1, 1'b0, 2'd0, 32'h0000_0000, 32'h8000_0000, 32'h0);  // R11
    do_exc(5'd14, 32'h0000_B000, 1'b0, 1'b0, 2'd0, 32'h0000_0000, 32'h0, 32'h0);          // R1 ignored
    do_exc(5'd20, 32'h0000_B004, 1'b1, 1'b0, 2'd0, 32'h0040_0000, 32'hFFFF_FFFF, 32'h0);  // R1 ignored

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] st;
      st = $urandom;
      if ($urandom_range(3) == 0) st[1] = 1'b1; else st[1] = 1'b0;
      do_exc(5'($urandom), $urandom, 1'($urandom), 1'($urandom), 2'($urandom),
             st, $urandom, $urandom);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule